// File: doc/BRIEF.md
# Coarse-Fine Arrival Timestamp Capture

This block stamps the arrival time of an event on each of several independent channels. A free-running binary coarse counter gives whole clock periods. A snapshot of a multiphase clock gives the position inside the current period. The phases are generated elsewhere and shared by every channel, and they arrive as a 64-bit vector. Their taps are ordered so that a pattern of ones filling from bit 0 upward marks how far the period has advanced. The block cleans single-bit bubbles out of that vector, encodes it to a 6-bit phase index, and joins the index to a 12-bit coarse value to form an 18-bit stamp. The fine index is a unitless phase number, because the delay step behind it is tuned outside this block.

Each channel owns a two-state capture slot. The states are EMPTY and HELD. The transition EMPTY to HELD (CAPTURE) fires on the channel's trigger pulse, which is the same pulse that freezes that channel's sample memory. The transition HELD to EMPTY (RELEASE) fires when the channel controller pulses the release input. While a slot is HELD, it ignores further triggers and holds its stamp.

The coarse counter can step close to the moment the phase snapshot is taken, so a second copy of the count is kept that lags the first by one update. The top bit of the fine index picks which copy goes into the stamp. This removes the rollover ambiguity.

Top module: `ts_capture_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the coarse counter, its lagging copy, every `valid_o` bit and every stamp in `ts_o` to zero.
- R2: At each edge without reset, the coarse counter (12 bits) increments by one and wraps from 4095 to 0. The lagging copy takes the counter's value from before that edge. Right after reset, both are zero.
- R3: Phase encoding: bit 0 of `phase_i` is the earliest tap. A clean pattern of k ones in bits 0..k-1 and zeros above encodes to fine index k for k = 0..63. All 64 bits high encodes to 63.
- R4: Before encoding, each bit is replaced by the majority of itself and its two neighbours. A constant 1 is assumed below bit 0 and a constant 0 above bit 63. A single flipped bit lying at least three positions from the 1-to-0 transition therefore does not change the fine index.
- R5: The stamp is 18 bits: bits [5:0] hold the fine index and bits [17:6] hold the coarse value. The coarse value is the current counter when fine bit 5 is 1, and the lagging copy when fine bit 5 is 0. Both are taken at the edge that captures.
- R6: CAPTURE: when a slot is EMPTY and its `trig_i` bit is high at an edge, that edge sets its `valid_o` bit. The same edge loads the stamp built from that cycle's `phase_i` and counter values.
- R7: While a slot is HELD, its stamp does not change, and a trigger on that channel has no effect.
- R8: RELEASE: a `rel_i` pulse on a HELD slot returns it to EMPTY at the next edge, even if `trig_i` is also high. `rel_i` on an EMPTY slot is ignored. After a release, the last stamp stays visible on `ts_o`.
- R9: Channels are independent. Channels triggered in the same cycle all capture the same stamp from the shared snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | 64 | Snapshot of the shared multiphase clock, bit 0 earliest |
| trig_i | input | 16 | Per-channel trigger pulse |
| rel_i | input | 16 | Per-channel release pulse from the channel controller |
| valid_o | output | 16 | Per-channel flag: a stamp is held |
| ts_o | output | 288 | Per-channel 18-bit stamps, channel n in bits [18n+17:18n] |

## Verification
A capture is due at the first edge after the cycle in which the trigger is high: the flag and the stamp both appear there, because only the slot register lies between the trigger and the output. A release clears the flag at the first edge after the pulse. The coarse value in a stamp is the counter value that was present just before the capturing edge. The bench drives inputs after a falling edge and keeps its own count of the non-reset edges. It predicts each slot's flag and stamp for the next edge, and compares them at the following falling edge, one full edge after the stimulus. The wrap cases are placed at counts 4096 and 8192, so that both counter copies straddle the rollover.

// File: rtl/ts_capture_pkg.sv
package ts_capture_pkg;

    localparam int DEF_NUM_CH = 16;
    localparam int DEF_PHASES = 64;
    localparam int DEF_TS_W   = 18;

    // Capture slot states
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_t;

endpackage

// File: rtl/ts_coarse_ctr.sv
module ts_coarse_ctr #(
    parameter int COARSE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    output logic [COARSE_W-1:0] cnt_now,
    output logic [COARSE_W-1:0] cnt_late
);

    // Free-running period counter plus a copy lagging by one update.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_now  <= '0;
            cnt_late <= '0;
        end else begin
            cnt_now  <= cnt_now + 1'b1;
            cnt_late <= cnt_now;
        end
    end

endmodule

// File: rtl/ts_phase_encoder.sv
module ts_phase_encoder #(
    parameter int PHASES = 64,
    localparam int FINE_W = $clog2(PHASES)
) (
    input  logic [PHASES-1:0] snap,
    output logic [FINE_W-1:0] fine
);

    // Pad with a virtual high tap below bit 0 and a low tap above the top.
    logic [PHASES+1:0] padded;
    logic [PHASES-1:0] filt;

    assign padded = {1'b0, snap, 1'b1};

    // Majority-of-three bubble filter
    for (genvar k = 0; k < PHASES; k++) begin : g_filt
        assign filt[k] = (padded[k] & padded[k+1]) |
                         (padded[k] & padded[k+2]) |
                         (padded[k+1] & padded[k+2]);
    end

    // Lowest low tap marks the transition; saturate when none is low.
    always_comb begin
        fine = FINE_W'(PHASES - 1);
        for (int k = PHASES - 1; k >= 0; k--) begin
            if (!filt[k]) begin
                fine = FINE_W'(k);
            end
        end
    end

endmodule

// File: rtl/ts_chan_slot.sv
module ts_chan_slot
    import ts_capture_pkg::*;
#(
    parameter int TS_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic            rel,
    input  logic [TS_W-1:0] stamp,
    output logic            valid,
    output logic [TS_W-1:0] ts
);

    slot_state_t state_q;
    slot_state_t state_d;
    logic        load;
    logic [TS_W-1:0] ts_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: CAPTURE (EMPTY->HELD), RELEASE (HELD->EMPTY)
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (trig) begin
                    state_d = SLOT_HELD;
                    load    = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (rel) begin
                    state_d = SLOT_EMPTY;
                end
            end
        endcase
    end

    // Stamp register
    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= '0;
        end else if (load) begin
            ts_q <= stamp;
        end
    end

    // Outputs
    always_comb begin
        valid = (state_q == SLOT_HELD);
        ts    = ts_q;
    end

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_capture_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int PHASES = DEF_PHASES,
    parameter int TS_W   = DEF_TS_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PHASES-1:0]      phase_i,
    input  logic [NUM_CH-1:0]      trig_i,
    input  logic [NUM_CH-1:0]      rel_i,
    output logic [NUM_CH-1:0]      valid_o,
    output logic [NUM_CH*TS_W-1:0] ts_o
);

    localparam int FINE_W   = $clog2(PHASES);
    localparam int COARSE_W = TS_W - FINE_W;

    logic [COARSE_W-1:0] coarse_now;
    logic [COARSE_W-1:0] coarse_late;
    logic [FINE_W-1:0]   fine_code;
    logic [COARSE_W-1:0] coarse_sel;
    logic [TS_W-1:0]     stamp;

    ts_coarse_ctr #(
        .COARSE_W (COARSE_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .cnt_now  (coarse_now),
        .cnt_late (coarse_late)
    );

    ts_phase_encoder #(
        .PHASES (PHASES)
    ) u_enc (
        .snap (phase_i),
        .fine (fine_code)
    );

    // Late-half phase: counter settled, take it; early half: use lagging copy.
    assign coarse_sel = fine_code[FINE_W-1] ? coarse_now : coarse_late;
    assign stamp      = {coarse_sel, fine_code};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
        ts_chan_slot #(
            .TS_W (TS_W)
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .trig  (trig_i[ch]),
            .rel   (rel_i[ch]),
            .stamp (stamp),
            .valid (valid_o[ch]),
            .ts    (ts_o[ch*TS_W +: TS_W])
        );
    end

endmodule

// File: rtl/ts_capture_checker.sv
module ts_capture_checker #(
    parameter int NUM_CH   = 16,
    parameter int TS_W     = 18,
    parameter int FINE_W   = 6,
    parameter int COARSE_W = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CH-1:0]      trig_i,
    input logic [NUM_CH-1:0]      rel_i,
    input logic [NUM_CH-1:0]      valid_o,
    input logic [NUM_CH*TS_W-1:0] ts_o,
    input logic [COARSE_W-1:0]    cnt_now,
    input logic [COARSE_W-1:0]    cnt_late,
    input logic [FINE_W-1:0]      fine
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (valid_o == '0 && ts_o == '0 && cnt_now == '0 && cnt_late == '0));

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_now == $past(cnt_now) + 1'b1);

    a_r2_late_copy: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_late == $past(cnt_now));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        a_r6_capture_flag: assert property (@(posedge clk) disable iff (rst)
            (!valid_o[i] && trig_i[i]) |=> valid_o[i]);

        a_r5_capture_value: assert property (@(posedge clk) disable iff (rst)
            (!valid_o[i] && trig_i[i]) |=>
                (ts_o[i*TS_W +: FINE_W] == $past(fine)) &&
                (ts_o[i*TS_W+FINE_W +: COARSE_W] ==
                    ($past(fine[FINE_W-1]) ? $past(cnt_now) : $past(cnt_late))));

        a_r7_hold_stamp: assert property (@(posedge clk) disable iff (rst)
            (valid_o[i] && !rel_i[i]) |=> valid_o[i] && $stable(ts_o[i*TS_W +: TS_W]));

        a_r8_release: assert property (@(posedge clk) disable iff (rst)
            (valid_o[i] && rel_i[i]) |=> !valid_o[i] && $stable(ts_o[i*TS_W +: TS_W]));

        a_r8_empty_idle: assert property (@(posedge clk) disable iff (rst)
            (!valid_o[i] && !trig_i[i]) |=> !valid_o[i] && $stable(ts_o[i*TS_W +: TS_W]));
    end

endmodule

bind ts_capture_unit ts_capture_checker #(
    .NUM_CH   (NUM_CH),
    .TS_W     (TS_W),
    .FINE_W   (FINE_W),
    .COARSE_W (COARSE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .rel_i    (rel_i),
    .valid_o  (valid_o),
    .ts_o     (ts_o),
    .cnt_now  (coarse_now),
    .cnt_late (coarse_late),
    .fine     (fine_code)
);

// File: tb/ts_capture_unit_bench.sv
`timescale 1ns/1ps
module ts_capture_unit_bench;

    localparam int NCH = 16;
    localparam int NPH = 64;
    localparam int TSW = 18;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NPH-1:0]     phase_i = '0;
    logic [NCH-1:0]     trig_i = '0;
    logic [NCH-1:0]     rel_i = '0;
    logic [NCH-1:0]     valid_o;
    logic [NCH*TSW-1:0] ts_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ncyc     = 0;
    bit done     = 1'b0;

    logic           exp_valid [NCH];
    logic [TSW-1:0] exp_ts    [NCH];

    ts_capture_unit u_ts_capture_unit (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .trig_i  (trig_i),
        .rel_i   (rel_i),
        .valid_o (valid_o),
        .ts_o    (ts_o)
    );

    always #5 clk = ~clk;

    // Count of non-reset edges = counter value before the next edge (R2)
    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    function automatic logic [NPH-1:0] therm(input int k);
        logic [NPH-1:0] v;
        for (int i = 0; i < NPH; i++) v[i] = (i < k);
        return v;
    endfunction

    function automatic int fine_of(input int k);
        return (k > NPH - 1) ? NPH - 1 : k;
    endfunction

    function automatic logic [TSW-1:0] stamp_of(input int k, input int c);
        int f;
        int crs;
        f   = fine_of(k);
        crs = (f >= 32) ? (c % 4096) : ((c == 0) ? 0 : ((c - 1) % 4096));
        return {12'(crs), 6'(f)};
    endfunction

    // A legal bubble position at least three taps from the transition, or -1
    function automatic int pick_bubble(input int k);
        int b;
        b = int'($urandom_range(0, NPH - 1));
        if (b <= k - 3 || b >= k + 3) return b;
        return -1;
    endfunction

    task automatic check_all(input string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            n_checks++;
            if (valid_o[ch] !== exp_valid[ch] || ts_o[ch*TSW +: TSW] !== exp_ts[ch]) begin
                n_fail++;
                $display("FAIL %s ch%0d: valid act=%0b exp=%0b ts act=%h exp=%h",
                         tag, ch, valid_o[ch], exp_valid[ch], ts_o[ch*TSW +: TSW], exp_ts[ch]);
            end
        end
    endtask

    // Drive one cycle of stimulus after a falling edge, check after the next.
    task automatic cycle(input logic [NCH-1:0] tg, input logic [NCH-1:0] rl,
                         input int k, input int bub, input string tag);
        logic [NPH-1:0] snap;
        logic [TSW-1:0] st;
        snap = therm(k);
        if (bub >= 0) snap[bub] = ~snap[bub];
        st = stamp_of(k, ncyc);
        for (int ch = 0; ch < NCH; ch++) begin
            if (exp_valid[ch]) begin
                if (rl[ch]) exp_valid[ch] = 1'b0;
            end else if (tg[ch]) begin
                exp_valid[ch] = 1'b1;
                exp_ts[ch]    = st;
            end
        end
        phase_i = snap;
        trig_i  = tg;
        rel_i   = rl;
        @(negedge clk);
        trig_i = '0;
        rel_i  = '0;
        check_all(tag);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, act=timeout exp=completion");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd7741));
        for (int ch = 0; ch < NCH; ch++) begin
            exp_valid[ch] = 1'b0;
            exp_ts[ch]    = '0;
        end
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst = 1'b0;

        // Directed corner cases
        cycle(16'h0001, 16'h0000, 10, -1, "R3 R5 R6 capture early-half phase");
        cycle(16'h0001, 16'h0000, 50, -1, "R7 trigger while held ignored");
        cycle(16'h0001, 16'h0001, 20, -1, "R8 release wins over trigger");
        cycle(16'h0002, 16'h0002, 40, -1, "R8 release on empty ignored, R5 late-half");
        cycle(16'h0004, 16'h0000, 64, -1, "R3 all ones saturates to 63");
        cycle(16'h0008, 16'h0000, 0,  -1, "R3 all zeros");
        cycle(16'h0010, 16'h0000, 20, 5,  "R4 zero bubble in ones");
        cycle(16'h0020, 16'h0000, 20, 40, "R4 one bubble in zeros");
        cycle(16'h0040, 16'h0000, 3,  0,  "R4 bubble at bottom tap");
        cycle(16'h0080, 16'h0000, 61, 63, "R4 bubble at top tap");
        cycle(16'h0000, 16'hFFFF, 0,  -1, "R8 release all, stamps stay");
        cycle(16'hFFFF, 16'h0000, 33, -1, "R9 simultaneous capture same stamp");
        cycle(16'h0000, 16'hFFFF, 0,  -1, "R8 release all");

        // Constrained random traffic
        for (int n = 0; n < 400; n++) begin
            logic [NCH-1:0] tg;
            logic [NCH-1:0] rl;
            int k;
            tg = NCH'($urandom & $urandom);
            rl = NCH'($urandom & $urandom & $urandom);
            k  = int'($urandom_range(0, NPH));
            cycle(tg, rl, k, pick_bubble(k), "R6 R7 R8 R9 random");
        end
        cycle(16'h0000, 16'hFFFF, 0, -1, "R8 release all");

        // Counter rollover
        while (ncyc != 4096) cycle(16'h0000, 16'h0000, 0, -1, "R7 idle hold");
        cycle(16'h0100, 16'h0000, 5,  -1, "R2 wrap, lagging copy gives 4095");
        while (ncyc != 8192) cycle(16'h0000, 16'h0000, 0, -1, "R7 idle hold");
        cycle(16'h0200, 16'h0000, 40, -1, "R2 wrap, current copy gives 0");
        cycle(16'h0400, 16'h0000, 40, -1, "R2 increment after wrap");
        cycle(16'h0800, 16'h0000, 12, -1, "R2 lagging copy after wrap");

        done = 1'b1;
        finish_run();
    end

endmodule